// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block is the host-facing control core of a network adapter. The host writes 16-bit command words through a simple synchronous write port. Each word carries an operation code and an argument. The block decodes that word and keeps the small amount of state that the command set acts on: the selected register window, an interrupt enable mask, a status visibility mask, and a bank of eight sticky event bits. Internal sources set the event bits with single-cycle pulses.

The status word is always available on a combinational output. It shows the selected window, a busy flag, and the event bits that the visibility mask lets through. The interrupt request output is asserted while any enabled event is latched.

A global reset command returns all software-visible state to its reset values. The block then reports busy for a parameterised number of cycles, and it drops any command written during that time. The per-window registers, the datapath and the transceiver lie outside this block.

Top module: `cmd_status_unit`

## Requirements
- R1: A command word holds the operation code in bits 15..11 and the argument in bits 10..0. Argument bits that an operation does not use have no effect. Operation codes other than 0, 1, 12, 13, 14 and 15 change no state.
- R2: Operation 1 loads the window number from argument bits 2..0. The window number is reported in status bits 15..13 from the cycle after the write.
- R3: Status bit 12 is the busy flag and bits 11..8 read as zero. Status bits 7..0 are the latched event bits ANDed with the visibility mask.
- R4: An event pulse on src_evt bit n sets latched event bit n. The bit stays set until an acknowledge or a global reset clears it. The event bits are: 0 interrupt latch, 1 adapter failure, 2 transmit complete, 3 transmit available, 4 receive complete, 5 receive early, 6 interrupt requested, 7 update statistics.
- R5: Operation 13 clears each latched event bit whose matching argument bit (7..0) is 1. All other event bits are left as they were.
- R6: If an event bit is set by any source in the same cycle that an acknowledge clears it, the bit stays set.
- R7: Operation 12 sets event bit 6.
- R8: Operation 14 loads the interrupt mask from argument bits 7..0. irq_o is high while any of event bits 7..1 is latched with its mask bit set. irq_o responds in the cycle after the event bit or the mask changes.
- R9: In every cycle that irq_o is high, event bit 0 is set at the next clock edge.
- R10: Operation 15 loads the visibility mask from argument bits 7..0. Events that this mask hides are still latched, and they still drive irq_o.
- R11: Operation 0 clears all event bits and sets the window to 0, the interrupt mask to 0x00 and the visibility mask to 0xFF. It then holds busy high for BUSY_CYCLES cycles (16 by default). The rst_n input gives the same state, with busy low.
- R12: A command written while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: operation code and argument |
| src_evt | input | 8 | Single-cycle event pulses, one bit per event |
| status_o | output | 16 | Status word: window, busy flag, visible events |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check the per-bit event rules on every cycle. They cover a set that wins over an acknowledge, a clear when an acknowledge is uncontested, and the latch of bit 0 whenever the request output is high. They also check that a window select lands on the next edge, that state stays frozen when a command arrives while busy, and that the busy counter stays bounded. The directed scenarios show what only a sequence can show. These are the exact length of the busy period, the reset values of both masks, and hidden events that still raise the interrupt. They also show the order in which an acknowledge and a pending interrupt resolve the latch bit, and that unknown operation codes leave the status word unchanged.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OPC_GLOBAL_RST = 5'd0,
      OPC_WIN_SEL    = 5'd1,
      OPC_INT_REQ    = 5'd12,
      OPC_EVT_ACK    = 5'd13,
      OPC_INT_MASK   = 5'd14,
      OPC_VIS_MASK   = 5'd15
   } opcode_e;

   localparam int EVT_LATCH_BIT = 0;
   localparam int EVT_REQ_BIT   = 6;
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
   import cmd_status_pkg::*;
#(
   parameter int CMD_W   = 16,
   parameter int NUM_EVT = 8,
   parameter int WIN_W   = 3
) (
   input  logic               we,
   input  logic               busy,
   input  logic [CMD_W-1:0]   data,
   output logic               do_rst,
   output logic               do_win,
   output logic               do_req,
   output logic               do_ack,
   output logic               do_imask,
   output logic               do_vmask,
   output logic [NUM_EVT-1:0] arg_evt,
   output logic [WIN_W-1:0]   arg_win
);
   localparam int ARG_W = CMD_W - OPC_W;

   logic             accept;
   logic [OPC_W-1:0] opc;
   logic [ARG_W-1:0] arg;

   assign accept  = we && !busy;
   assign opc     = data[CMD_W-1 -: OPC_W];
   assign arg     = data[ARG_W-1:0];
   assign arg_evt = arg[NUM_EVT-1:0];
   assign arg_win = arg[WIN_W-1:0];

   always_comb begin
      do_rst   = 1'b0;
      do_win   = 1'b0;
      do_req   = 1'b0;
      do_ack   = 1'b0;
      do_imask = 1'b0;
      do_vmask = 1'b0;
      if (accept) begin
         case (opc)
            OPC_GLOBAL_RST: do_rst   = 1'b1;
            OPC_WIN_SEL:    do_win   = 1'b1;
            OPC_INT_REQ:    do_req   = 1'b1;
            OPC_EVT_ACK:    do_ack   = 1'b1;
            OPC_INT_MASK:   do_imask = 1'b1;
            OPC_VIS_MASK:   do_vmask = 1'b1;
            default: ;
         endcase
      end
   end

   generate
      if (NUM_EVT < ARG_W) begin : g_spare
         logic unused_arg_hi;
         assign unused_arg_hi = ^arg[ARG_W-1:NUM_EVT];
      end
   endgenerate

   always_comb begin
      AST_ONE_STROBE: assert ($countones({do_rst, do_win, do_req, do_ack,
                                         do_imask, do_vmask}) <= 1); // R1
   end
endmodule

// File: rtl/evt_bank.sv
module evt_bank #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_all,
   input  logic [NUM_EVT-1:0] set_vec,
   input  logic [NUM_EVT-1:0] ack_vec,
   output logic [NUM_EVT-1:0] evt_q
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_EVT; gi++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              evt_q[gi] <= 1'b0;
            else if (clr_all)        evt_q[gi] <= 1'b0;
            else if (set_vec[gi])    evt_q[gi] <= 1'b1;
            else if (ack_vec[gi])    evt_q[gi] <= 1'b0;
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[gi] && !clr_all) |=> evt_q[gi]); // R6
         AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vec[gi] && !set_vec[gi]) |=> !evt_q[gi]); // R5
         AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_q[gi] && !ack_vec[gi] && !clr_all) |=> evt_q[gi]); // R4
      end
   endgenerate
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
   parameter int BUSY_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BUSY_CYCLES)); // R11
   AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy); // R11
endmodule

// File: rtl/cmd_status_unit.sv
module cmd_status_unit
   import cmd_status_pkg::*;
#(
   parameter int CMD_W       = 16,
   parameter int NUM_EVT     = 8,
   parameter int WIN_W       = 3,
   parameter int BUSY_CYCLES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_we,
   input  logic [CMD_W-1:0]   cmd_data,
   input  logic [NUM_EVT-1:0] src_evt,
   output logic [CMD_W-1:0]   status_o,
   output logic               irq_o
);
   localparam int ARG_W  = CMD_W - OPC_W;
   localparam int RSVD_W = CMD_W - WIN_W - 1 - NUM_EVT;

   generate
      if (NUM_EVT > ARG_W || NUM_EVT <= EVT_REQ_BIT) begin : g_bad_evt
         $error("NUM_EVT must cover the request bit and fit the argument");
      end
      if (WIN_W > ARG_W || RSVD_W < 0) begin : g_bad_win
         $error("status word cannot hold window, busy and events");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic               busy;
   logic               do_rst, do_win, do_req, do_ack, do_imask, do_vmask;
   logic [NUM_EVT-1:0] arg_evt;
   logic [WIN_W-1:0]   arg_win;
   logic [NUM_EVT-1:0] evt_q, set_vec, ack_vec;
   logic [NUM_EVT-1:0] imask_q, vmask_q;
   logic [WIN_W-1:0]   win_q;

   cmd_decoder #(.CMD_W(CMD_W), .NUM_EVT(NUM_EVT), .WIN_W(WIN_W)) u_dec (
      .we(cmd_we), .busy(busy), .data(cmd_data),
      .do_rst(do_rst), .do_win(do_win), .do_req(do_req), .do_ack(do_ack),
      .do_imask(do_imask), .do_vmask(do_vmask),
      .arg_evt(arg_evt), .arg_win(arg_win)
   );

   busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .load(do_rst), .busy(busy)
   );

   always_comb begin
      set_vec = src_evt;
      set_vec[EVT_REQ_BIT]   = src_evt[EVT_REQ_BIT] | do_req;
      set_vec[EVT_LATCH_BIT] = src_evt[EVT_LATCH_BIT] | irq_o;
      ack_vec = do_ack ? arg_evt : '0;
   end

   evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
      .clk(clk), .rst_n(rst_n), .clr_all(do_rst),
      .set_vec(set_vec), .ack_vec(ack_vec), .evt_q(evt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= '0;
         imask_q <= '0;
         vmask_q <= '1;
      end else if (do_rst) begin
         win_q   <= '0;
         imask_q <= '0;
         vmask_q <= '1;
      end else begin
         if (do_win)   win_q   <= arg_win;
         if (do_imask) imask_q <= arg_evt;
         if (do_vmask) vmask_q <= arg_evt;
      end
   end

   assign irq_o    = |(evt_q[NUM_EVT-1:1] & imask_q[NUM_EVT-1:1]);
   assign status_o = {win_q, busy, {RSVD_W{1'b0}}, evt_q & vmask_q};

   AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !busy && cmd_data[CMD_W-1 -: OPC_W] == OPC_WIN_SEL)
      |=> win_q == $past(cmd_data[WIN_W-1:0])); // R2
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && busy) |=> ($stable(win_q) && $stable(imask_q)
                            && $stable(vmask_q))); // R12
   AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !do_rst) |=> evt_q[EVT_LATCH_BIT]); // R9
   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      do_req |=> evt_q[EVT_REQ_BIT]); // R7
endmodule

// File: tb/tb_cmd_status_unit.sv
module tb_cmd_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_data = '0;
   logic [7:0]  src_evt = '0;
   logic [15:0] status_o;
   logic        irq_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   cmd_status_unit dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .src_evt(src_evt), .status_o(status_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [4:0] op, input logic [10:0] arg,
                      input logic [7:0] ev = 8'h00);
      cmd_we   = 1'b1;
      cmd_data = {op, arg};
      src_evt  = ev;
      @(negedge clk);
      cmd_we   = 1'b0;
      src_evt  = 8'h00;
   endtask

   task automatic pulse(input logic [7:0] ev);
      src_evt = ev;
      @(negedge clk);
      src_evt = 8'h00;
   endtask

   task automatic t_reset;
      chk("R11 reset status", status_o, 16'h0000);
      chk("R11 reset irq", {15'd0, irq_o}, 16'h0000);
   endtask

   task automatic t_window;
      cmd(5'd1, 11'h7FD);  // R1 upper argument bits ignored, R2 window 5
      chk("R2 window", {13'd0, status_o[15:13]}, 16'd5);
      chk("R3 reserved zero", {12'd0, status_o[11:8]}, 16'd0);
   endtask

   task automatic t_events;
      pulse(8'h14);
      chk("R4 latch", {8'd0, status_o[7:0]}, 16'h0014);
      @(negedge clk);
      chk("R4 sticky", {8'd0, status_o[7:0]}, 16'h0014);
      cmd(5'd13, 11'h004);
      chk("R5 ack one bit", {8'd0, status_o[7:0]}, 16'h0010);
   endtask

   task automatic t_same_cycle;
      cmd(5'd13, 11'h010, 8'h10);
      chk("R6 set beats ack", {8'd0, status_o[7:0]}, 16'h0010);
      cmd(5'd13, 11'h010);
      chk("R5 ack clears", {8'd0, status_o[7:0]}, 16'h0000);
   endtask

   task automatic t_irq;
      cmd(5'd12, 11'h000);
      chk("R7 request bit", {8'd0, status_o[7:0]}, 16'h0040);
      chk("R8 masked irq low", {15'd0, irq_o}, 16'd0);
      cmd(5'd14, 11'h040);
      chk("R8 irq high", {15'd0, irq_o}, 16'd1);
      chk("R9 latch not yet", {8'd0, status_o[7:0]}, 16'h0040);
      @(negedge clk);
      chk("R9 latch set", {8'd0, status_o[7:0]}, 16'h0041);
      cmd(5'd13, 11'h041);
      chk("R9 latch held by live irq", {8'd0, status_o[7:0]}, 16'h0001);
      chk("R8 irq dropped", {15'd0, irq_o}, 16'd0);
      cmd(5'd13, 11'h001);
      chk("R5 latch acked", {8'd0, status_o[7:0]}, 16'h0000);
   endtask

   task automatic t_vis_mask;
      cmd(5'd15, 11'h00F);
      pulse(8'h30);
      chk("R10 hidden", {8'd0, status_o[7:0]}, 16'h0000);
      cmd(5'd14, 11'h020);
      chk("R10 hidden drives irq", {15'd0, irq_o}, 16'd1);
      @(negedge clk);
      chk("R10 latch visible", {8'd0, status_o[7:0]}, 16'h0001);
      cmd(5'd15, 11'h0FF);
      chk("R10 reveal", {8'd0, status_o[7:0]}, 16'h0031);
   endtask

   task automatic t_unknown;
      cmd(5'd7, 11'h7FF);
      cmd(5'd21, 11'h7FF);
      chk("R1 unknown opcode", status_o, 16'hA031);
      chk("R1 unknown irq", {15'd0, irq_o}, 16'd1);
   endtask

   task automatic t_global;
      int n;
      cmd(5'd0, 11'h000);
      chk("R11 busy and cleared", status_o, 16'h1000);
      chk("R11 irq cleared", {15'd0, irq_o}, 16'd0);
      cmd(5'd1, 11'h003);
      n = 0;
      while (status_o[12] && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R11 busy length", 16'(n + 1), 16'd16);
      chk("R12 ignored while busy", status_o, 16'h0000);
      cmd(5'd1, 11'h003);
      chk("R12 accepted after busy", {13'd0, status_o[15:13]}, 16'd3);
      pulse(8'h80);
      chk("R11 vis mask reset", status_o, 16'h6080);
      chk("R11 int mask reset", {15'd0, irq_o}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_window;
      t_events;
      t_same_cycle;
      t_irq;
      t_vis_mask;
      t_unknown;
      t_global;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule